// File: doc/BRIEF.md
# Configuration-Port Warm-Reboot Sequencer

This block makes an FPGA reload its own configuration from a chosen flash location. On a start pulse it captures a 24-bit primary image address, a 24-bit fallback image address and an 8-bit flash read opcode. It then plays a fixed script of fourteen 16-bit words into the device's internal configuration port, one word per accepted beat. The script is a dummy word, two synchronisation words, four single-word writes to the general-purpose boot registers, and a command-register write that carries the reboot code followed by a no-operation word.

The port takes a word in any cycle where the enable is high and the port's stall input is low. Enable and write stay asserted for the whole script. Every word is bit-reversed inside each byte on its way out, which is the order the port expects. The block reports busy while the script runs and pulses done when it has finished. If the port stalls for too long, a watchdog abandons the script and raises an error flag.

Top module: `cfg_reload_seq`

## Requirements
- R1: After reset, port_en_o, port_wr_o, busy_o, done_o and timeout_err_o are all low.
- R2: A start_i pulse seen while idle raises port_en_o, port_wr_o and busy_o on the next cycle, and the first word presented is 0xFFFF.
- R3: Before the byte swap, the words presented are, in this order: 0xFFFF, 0xAA99, 0x5566, 0x3261, primary[15:0], 0x3281, opcode word (primary), 0x32A1, fallback[15:0], 0x32C1, opcode word (fallback), 0x30A1, 0x000E, 0x2000.
- R4: An opcode word holds the read opcode in bits [15:8] and the address bits [23:16] in bits [7:0].
- R5: Output bit 8*b+k equals script-word bit 8*b+7-k, for byte b in 0..1 and k in 0..7.
- R6: The script advances by one word only on a cycle where port_en_o is high and port_stall_i is low. While stalled, the presented word holds.
- R7: start_i and the address and opcode inputs have no effect while busy. The script uses the values captured at the accepted start.
- R8: In the cycle after the final word (0x2000) is accepted, done_o is high for exactly one cycle, and port_en_o and busy_o are low.
- R9: If port_stall_i is high for WD_LIMIT (default 4096) consecutive busy cycles, the next cycle has port_en_o low, timeout_err_o high and done_o low. WD_LIMIT-1 stalled cycles do not abort.
- R10: timeout_err_o stays high until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a reboot script (ignored when busy) |
| boot_addr_i | input | 24 | Primary image flash address |
| fallback_addr_i | input | 24 | Fallback image flash address |
| read_op_i | input | 8 | Flash read opcode |
| port_stall_i | input | 1 | Port cannot take a word this cycle |
| port_en_o | output | 1 | Port enable, word valid |
| port_wr_o | output | 1 | Port write direction |
| port_word_o | output | 16 | Byte-wise bit-reversed script word |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_err_o | output | 1 | Watchdog abort flag |

## Verification
The script is replayed under several address and opcode patterns. These include all-ones, all-zeros, alternating and asymmetric values, so that the address halves, the opcode placement and the per-byte reversal can be told apart from each other and from byte swaps. Each pattern runs with no stall, with alternate-cycle stall and with every-third-cycle stall, which separates the advance-on-accept rule from a free-running step. One run holds start high with changing inputs throughout, to show the captured values are kept. Stall runs of exactly one short of the watchdog limit and exactly at the limit mark the abort threshold, and a restart after the abort shows the error flag clears.

// File: rtl/cfg_reload_pkg.sv
package cfg_reload_pkg;
    localparam int WORD_W     = 16;
    localparam int ADDR_W     = 24;
    localparam int OP_W       = 8;
    localparam int BYTE_W     = 8;
    localparam int N_BYTES    = WORD_W / BYTE_W;
    localparam int SCRIPT_LEN = 14;
    localparam int STEP_W     = $clog2(SCRIPT_LEN);

    typedef logic [STEP_W-1:0] step_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam step_t LAST_STEP = step_t'(SCRIPT_LEN - 1);

    localparam word_t W_DUMMY = 16'hFFFF;
    localparam word_t W_SYNC0 = 16'hAA99;
    localparam word_t W_SYNC1 = 16'h5566;
    localparam word_t W_NOOP  = 16'h2000;
    localparam word_t W_BOOT  = 16'h000E;

    localparam logic [1:0] HDR_WRITE = 2'b10;

    // type-1 header: 001, op, 6-bit register, 5-bit count
    function automatic word_t hdr1(input logic [5:0] reg_sel, input logic [4:0] cnt);
        return {3'b001, HDR_WRITE, reg_sel, cnt};
    endfunction
endpackage

// File: rtl/cfg_script_rom.sv
module cfg_script_rom
    import cfg_reload_pkg::*;
(
    input  step_t                  step_i,
    input  logic [ADDR_W-1:0]      boot_i,
    input  logic [ADDR_W-1:0]      fall_i,
    input  logic [OP_W-1:0]        op_i,
    output word_t                  word_o
);
    localparam logic [5:0] REG_CMD  = 6'h05;
    localparam logic [5:0] REG_GEN1 = 6'h13;
    localparam logic [5:0] REG_GEN2 = 6'h14;
    localparam logic [5:0] REG_GEN3 = 6'h15;
    localparam logic [5:0] REG_GEN4 = 6'h16;

    always_comb begin
        unique case (step_i)
            step_t'(0):  word_o = W_DUMMY;
            step_t'(1):  word_o = W_SYNC0;
            step_t'(2):  word_o = W_SYNC1;
            step_t'(3):  word_o = hdr1(REG_GEN1, 5'd1);
            step_t'(4):  word_o = boot_i[WORD_W-1:0];
            step_t'(5):  word_o = hdr1(REG_GEN2, 5'd1);
            step_t'(6):  word_o = {op_i, boot_i[ADDR_W-1:WORD_W]};
            step_t'(7):  word_o = hdr1(REG_GEN3, 5'd1);
            step_t'(8):  word_o = fall_i[WORD_W-1:0];
            step_t'(9):  word_o = hdr1(REG_GEN4, 5'd1);
            step_t'(10): word_o = {op_i, fall_i[ADDR_W-1:WORD_W]};
            step_t'(11): word_o = hdr1(REG_CMD, 5'd1);
            step_t'(12): word_o = W_BOOT;
            default:     word_o = W_NOOP;
        endcase
    end
endmodule

// File: rtl/cfg_byte_bitrev.sv
module cfg_byte_bitrev
    import cfg_reload_pkg::*;
(
    input  word_t in_i,
    output word_t out_o
);
    for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
        for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
            assign out_o[b*BYTE_W + k] = in_i[b*BYTE_W + (BYTE_W-1-k)];
        end
    end
endmodule

// File: rtl/cfg_reload_seq.sv
module cfg_reload_seq
    import cfg_reload_pkg::*;
#(
    parameter int WD_LIMIT = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] boot_addr_i,
    input  logic [ADDR_W-1:0] fallback_addr_i,
    input  logic [OP_W-1:0]   read_op_i,
    input  logic              port_stall_i,
    output logic              port_en_o,
    output logic              port_wr_o,
    output logic [WORD_W-1:0] port_word_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_err_o
);
    localparam int CNT_W = $clog2(WD_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WD_LIMIT - 1);

    typedef struct packed {
        logic              busy;
        step_t             step;
        logic [ADDR_W-1:0] boot;
        logic [ADDR_W-1:0] fall;
        logic [OP_W-1:0]   op;
        logic [CNT_W-1:0]  stall_cnt;
        logic              done;
        logic              err;
    } seq_state_t;

    seq_state_t st_q, st_d;
    word_t      raw_word;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy      = 1'b1;
                st_d.step      = '0;
                st_d.boot      = boot_addr_i;
                st_d.fall      = fallback_addr_i;
                st_d.op        = read_op_i;
                st_d.stall_cnt = '0;
                st_d.err       = 1'b0;
            end
        end else if (port_stall_i) begin
            if (st_q.stall_cnt == CNT_LAST) begin
                st_d.busy      = 1'b0;
                st_d.err       = 1'b1;
                st_d.stall_cnt = '0;
            end else begin
                st_d.stall_cnt = st_q.stall_cnt + CNT_W'(1);
            end
        end else begin
            st_d.stall_cnt = '0;
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + step_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cfg_script_rom i_rom (
        .step_i (st_q.step),
        .boot_i (st_q.boot),
        .fall_i (st_q.fall),
        .op_i   (st_q.op),
        .word_o (raw_word)
    );

    cfg_byte_bitrev i_rev (
        .in_i  (raw_word),
        .out_o (port_word_o)
    );

    assign port_en_o     = st_q.busy;
    assign port_wr_o     = st_q.busy;
    assign busy_o        = st_q.busy;
    assign done_o        = st_q.done;
    assign timeout_err_o = st_q.err;
endmodule

// File: rtl/cfg_reload_seq_chk.sv
module cfg_reload_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        port_stall_i,
    input logic        port_en_o,
    input logic [15:0] port_word_o,
    input logic        busy_o,
    input logic        done_o,
    input logic        timeout_err_o
);
    assert_first_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> port_word_o == 16'hFFFF);

    assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        port_en_o && port_stall_i |=> !port_en_o || $stable(port_word_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !port_en_o && !busy_o);

    assert_abort_after_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err_o) |-> !port_en_o && !done_o && $past(port_en_o && port_stall_i));

    assert_err_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err_o && !busy_o |=> timeout_err_o || busy_o);
endmodule

bind cfg_reload_seq cfg_reload_seq_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_stall_i  (port_stall_i),
    .port_en_o     (port_en_o),
    .port_word_o   (port_word_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/test_cfg_reload_seq.sv
module test_cfg_reload_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] boot_addr_i = '0;
    logic [23:0] fallback_addr_i = '0;
    logic [7:0]  read_op_i = '0;
    logic        port_stall_i = 1'b0;
    logic        port_en_o, port_wr_o, busy_o, done_o, timeout_err_o;
    logic [15:0] port_word_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cfg_reload_seq i_cfg_reload_seq (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_word(input int idx, input logic [23:0] b,
                                              input logic [23:0] f, input logic [7:0] op);
        logic [15:0] w, r;
        case (idx)
            0: w = 16'hFFFF;   1: w = 16'hAA99;   2: w = 16'h5566;
            3: w = 16'h3261;   4: w = b[15:0];    5: w = 16'h3281;
            6: w = {op, b[23:16]};                7: w = 16'h32A1;
            8: w = f[15:0];    9: w = 16'h32C1;
            10: w = {op, f[23:16]};               11: w = 16'h30A1;
            12: w = 16'h000E;  default: w = 16'h2000;
        endcase
        for (int k = 0; k < 16; k++) r[k] = w[(k/8)*8 + 7 - (k%8)];
        return r;
    endfunction

    // mode 0 none, 1 alternate stall, 2 every third stalled, 3 start held with junk inputs
    task automatic run_seq(input logic [23:0] b, input logic [23:0] f, input logic [7:0] op,
                           input int mode, input int pre_stall);
        int idx = 0;
        logic st;
        @(negedge clk);
        boot_addr_i = b; fallback_addr_i = f; read_op_i = op; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(port_en_o && port_wr_o && busy_o, "R2 en/wr/busy after start", {29'd0, port_en_o, port_wr_o, busy_o}, 32'h7);
        chk(port_word_o == 16'hFFFF, "R2 first word", port_word_o, 32'hFFFF);
        chk(!timeout_err_o, "R10 err cleared by start", timeout_err_o, 0);
        if (pre_stall > 0) begin
            port_stall_i = 1'b1;
            repeat (pre_stall) @(negedge clk);
            port_stall_i = 1'b0;
            if (pre_stall >= 4096) begin
                chk(!port_en_o && timeout_err_o && !done_o, "R9 abort at limit",
                    {29'd0, port_en_o, timeout_err_o, done_o}, 32'h2);
                repeat (3) @(negedge clk);
                chk(timeout_err_o && !port_en_o, "R10 err held while idle", timeout_err_o, 1);
                return;
            end
            chk(port_en_o && !timeout_err_o && port_word_o == exp_word(0, b, f, op),
                "R9 no abort below limit", port_word_o, exp_word(0, b, f, op));
        end
        while (idx < 14) begin
            chk(port_en_o && port_word_o == exp_word(idx, b, f, op),
                $sformatf("R3 R4 R5 R6 word %0d", idx), port_word_o, exp_word(idx, b, f, op));
            st = (mode == 1) ? cyc[0] : (mode == 2) ? (cyc % 3 == 0) : 1'b0;
            port_stall_i = st;
            if (mode == 3) begin
                start_i = (idx < 13);
                boot_addr_i = ~b ^ 24'(cyc); fallback_addr_i = ~f; read_op_i = ~op;
            end
            if (!st) begin
                if (idx == 13) start_i = 1'b0;
                idx++;
            end
            @(negedge clk);
        end
        port_stall_i = 1'b0; start_i = 1'b0;
        chk(done_o && !port_en_o && !busy_o, "R8 done after final word",
            {29'd0, done_o, port_en_o, busy_o}, 32'h4);
        if (mode == 3) chk(!busy_o, "R7 held start not restarted", busy_o, 0);
        @(negedge clk);
        chk(!done_o && !port_en_o, "R8 done one cycle", {30'd0, done_o, port_en_o}, 0);
    endtask

    initial begin
        logic [23:0] bs [5];
        logic [23:0] fs [5];
        logic [7:0]  ops [5];
        bs[0] = 24'hFFFFFF; fs[0] = 24'h000000; ops[0] = 8'h0B;
        bs[1] = 24'h000000; fs[1] = 24'hFFFFFF; ops[1] = 8'h03;
        bs[2] = 24'hA5C3F0; fs[2] = 24'h5A3C0F; ops[2] = 8'hEB;
        bs[3] = 24'h123456; fs[3] = 24'hFEDCBA; ops[3] = 8'h6B;
        bs[4] = 24'h010080; fs[4] = 24'h804001; ops[4] = 8'h81;
        repeat (3) @(negedge clk);
        chk(!port_en_o && !port_wr_o && !busy_o && !done_o && !timeout_err_o, "R1 reset outputs",
            {27'd0, port_en_o, port_wr_o, busy_o, done_o, timeout_err_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!port_en_o && !busy_o, "R1 idle after reset", {30'd0, port_en_o, busy_o}, 0);
        for (int p = 0; p < 5; p++)
            for (int m = 0; m < 4; m++)
                run_seq(bs[p], fs[p], ops[p], m, 0);
        run_seq(bs[2], fs[2], ops[2], 0, 4095);
        run_seq(bs[3], fs[3], ops[3], 0, 4096);
        run_seq(bs[4], fs[4], ops[4], 2, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog run did not finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule